// File: doc/BRIEF.md
# Brownout-Aware Reset Sequencer

This block produces the internal reset of a small microcontroller from two sources. One is an active-low external reset pin. The other is a digital brownout flag, driven by an analog supply comparator outside the block, that reads high while the supply is below its threshold. The brownout flag asserts the internal reset at once, without waiting for a clock edge. Its release and the whole external reset path pass through clocked synchronisers. A short glitch on the pin is filtered out.

Release is not a fixed stretch. A down-counting startup timer is loaded with a preset of the form 0x0Fn, where the low nibble n is a parameter. The timer holds that preset while either source asks for reset. Once both sources are quiet, it counts down on each clock where the timer-clock enable is high. Internal reset drops when the count underflows. Any new brownout or valid external reset reloads the timer, and the full countdown then starts again. A done output marks that the startup delay has run out. The same reset condition also inhibits the watchdog and the clock monitor.

Top module: `brownout_reset_seq`

## Requirements
- R1: While supply_low is high, core_rst is 1, startup_done is 0 and wd_inhibit is 1. A rising supply_low forces this state at once, without a clock edge.
- R2: While supply_low stays high, the timer is held at its preset and core_rst never drops, however many enabled timer clocks occur.
- R3: The preset is P = 0x0F0 | PRESET_NIBBLE, which is 240 by default. After supply_low falls, the two-flop synchroniser delays the first counting edge to the third clock edge. core_rst drops after the (P+1)-th counting edge on which tick is 1, that is on the underflow from 0.
- R4: A clock edge with tick low leaves the count unchanged. Release then comes later by exactly the number of such edges.
- R5: If supply_low rises after release, core_rst reasserts at once. After supply_low falls again, release needs a full new countdown of P+1 enabled edges.
- R6: If supply_low rises during a countdown, the timer reloads. After recovery, release needs a full countdown from the preset.
- R7: If ext_rst_n is low on MIN_LOW_CYCLES (default 4) or more consecutive clock edges, the reset is accepted. core_rst rises after edge MIN_LOW_CYCLES+2, counting the first edge that samples the low pin as edge 0.
- R8: A low pulse on ext_rst_n that covers fewer than MIN_LOW_CYCLES edges has no effect, and core_rst stays 0.
- R9: A valid external reset, including one that arrives during a countdown, reloads the timer. With tick held high, core_rst drops after edge P+3, counting the first edge that samples ext_rst_n high again as edge 0.
- R10: startup_done is high exactly while core_rst is low. It stays high until the next brownout or valid external reset. wd_inhibit equals core_rst at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| supply_low | input | 1 | Brownout flag from the supply comparator, high while the supply is below threshold |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| tick | input | 1 | Startup timer clock enable |
| core_rst | output | 1 | Internal reset to the device, active high |
| startup_done | output | 1 | The startup timer has underflowed and the timer is free |
| wd_inhibit | output | 1 | Holds the watchdog and the clock monitor inhibited |

## Verification
The bench measures the exact edge on which reset drops, for several tick duty patterns. A design that counted edges without tick, lost one synchroniser stage, or released on reaching zero rather than on underflow would miss that edge by at least one. A brownout in mid-countdown, a brownout after release, and an external reset during the countdown each check for a full reload. A sequencer that merely resumed, or that restarted from a reduced count, would release too early. Pin pulses one edge short of, and well beyond, the minimum width separate a correct glitch filter from one that lets short pulses reset the device or that is off by one. The brownout path is also checked for immediate assertion with no clock edge.

// File: rtl/brs_pkg.sv
package brs_pkg;

   // sequencer phase: reload, countdown, released
   typedef enum logic [1:0] {
      SEQ_LOAD  = 2'd0,
      SEQ_COUNT = 2'd1,
      SEQ_RUN   = 2'd2
   } seq_state_e;

   // preset of the form 0x0Fn
   function automatic int unsigned preset_of(input int unsigned nibble);
      return 32'h0F0 | (nibble & 32'hF);
   endfunction

endpackage

// File: rtl/brs_sync.sv
module brs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);

   logic [STAGES:0] chain;

   assign chain[0] = d;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or posedge arst) begin
         if (arst) chain[i+1] <= RST_VAL;
         else      chain[i+1] <= chain[i];
      end
   end

   assign q = chain[STAGES];

endmodule

// File: rtl/brs_pulse_qual.sv
module brs_pulse_qual #(
   parameter int MIN_LOW = 4
) (
   input  logic clk,
   input  logic arst,
   input  logic pin_s,
   output logic valid
);

   localparam int QW = (MIN_LOW < 1) ? 1 : $clog2(MIN_LOW + 1);
   localparam logic [QW-1:0] QMAX = QW'(MIN_LOW);

   logic [QW-1:0] low_cnt;

   always_ff @(posedge clk or posedge arst) begin
      if (arst)               low_cnt <= '0;
      else if (pin_s)         low_cnt <= '0;
      else if (low_cnt != QMAX) low_cnt <= low_cnt + 1'b1;
   end

   assign valid = (low_cnt == QMAX);

endmodule

// File: rtl/brs_idle_timer.sv
module brs_idle_timer #(
   parameter int TMR_W  = 16,
   parameter int PRESET = 240
) (
   input  logic             clk,
   input  logic             arst,
   input  logic             load,
   input  logic             en,
   input  logic             tick,
   output logic [TMR_W-1:0] count,
   output logic             underflow
);

   localparam logic [TMR_W-1:0] PRE = TMR_W'(PRESET);

   always_ff @(posedge clk or posedge arst) begin
      if (arst)             count <= PRE;
      else if (load)        count <= PRE;
      else if (en && tick)  count <= count - 1'b1;
   end

   assign underflow = en && tick && !load && (count == '0);

endmodule

// File: rtl/brownout_reset_seq.sv
module brownout_reset_seq #(
   parameter int TMR_W          = 16,
   parameter int PRESET_NIBBLE  = 0,
   parameter int MIN_LOW_CYCLES = 4,
   parameter int SYNC_STAGES    = 2
) (
   input  logic clk,
   input  logic supply_low,
   input  logic ext_rst_n,
   input  logic tick,
   output logic core_rst,
   output logic startup_done,
   output logic wd_inhibit
);
   import brs_pkg::*;

   localparam int PRESET_VAL = int'(preset_of(PRESET_NIBBLE));

   if (PRESET_NIBBLE < 0 || PRESET_NIBBLE > 15) begin : g_bad_nibble
      $error("PRESET_NIBBLE must be 0..15");
   end
   if (TMR_W < 8) begin : g_bad_width
      $error("TMR_W must hold the 0x0Fn preset");
   end
   if (MIN_LOW_CYCLES < 1) begin : g_bad_minlow
      $error("MIN_LOW_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             bo_s;
   logic             ext_s;
   logic             ext_valid;
   logic             hold;
   logic             tmr_en;
   logic             tmr_uf;
   logic [TMR_W-1:0] tmr_cnt;
   seq_state_e       state;

   brs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bo_sync (
      .clk(clk), .arst(supply_low), .d(supply_low), .q(bo_s)
   );

   brs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
      .clk(clk), .arst(supply_low), .d(ext_rst_n), .q(ext_s)
   );

   brs_pulse_qual #(.MIN_LOW(MIN_LOW_CYCLES)) u_qual (
      .clk(clk), .arst(supply_low), .pin_s(ext_s), .valid(ext_valid)
   );

   assign hold   = bo_s | ext_valid;
   assign tmr_en = !hold && (state != SEQ_RUN);

   brs_idle_timer #(.TMR_W(TMR_W), .PRESET(PRESET_VAL)) u_timer (
      .clk(clk), .arst(supply_low), .load(hold), .en(tmr_en),
      .tick(tick), .count(tmr_cnt), .underflow(tmr_uf)
   );

   always_ff @(posedge clk or posedge supply_low) begin
      if (supply_low)              state <= SEQ_LOAD;
      else if (hold)               state <= SEQ_LOAD;
      else if (tmr_uf)             state <= SEQ_RUN;
      else if (state == SEQ_LOAD)  state <= SEQ_COUNT;
   end

   assign core_rst     = (state != SEQ_RUN);
   assign startup_done = (state == SEQ_RUN);
   assign wd_inhibit   = core_rst;

endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
   parameter int TMR_W  = 16,
   parameter int PRESET = 240
) (
   input logic             clk,
   input logic             supply_low,
   input logic             tick,
   input logic             hold,
   input logic [TMR_W-1:0] cnt,
   input logic             core_rst
);

   // R2 R6 R9: a reset request reloads the timer and keeps reset asserted
   assert_hold_reloads_R2: assert property (@(posedge clk) disable iff (supply_low)
      hold |=> (core_rst && cnt == TMR_W'(PRESET)));

   // R3: an enabled edge during the countdown lowers the count by one
   assert_count_step_R3: assert property (@(posedge clk) disable iff (supply_low)
      (!hold && core_rst && tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   // R3: release only on an enabled underflow from zero
   assert_release_on_underflow_R3: assert property (@(posedge clk) disable iff (supply_low)
      $fell(core_rst) |-> ($past(cnt) == '0 && $past(tick) && !$past(hold)));

   // R4: an edge without tick freezes the count
   assert_tick_gate_R4: assert property (@(posedge clk) disable iff (supply_low)
      (core_rst && !hold && !tick) |=> $stable(cnt));

   // R10: released stays released until a new request
   assert_stay_released_R10: assert property (@(posedge clk) disable iff (supply_low)
      (!core_rst && !hold) |=> !core_rst);

endmodule

bind brownout_reset_seq brs_checker #(.TMR_W(TMR_W), .PRESET(PRESET_VAL)) u_chk (
   .clk(clk), .supply_low(supply_low), .tick(tick), .hold(hold),
   .cnt(tmr_cnt), .core_rst(core_rst)
);

// File: tb/tb_brownout_reset_seq.sv
module tb_brownout_reset_seq;

   localparam int CLK_PERIOD = 10;
   localparam int P          = 240;
   localparam int MINL       = 4;
   localparam int NVEC       = 4;
   // tick divider, expected release edge after supply recovery
   localparam int VEC [NVEC][2] = '{'{1, 242}, '{2, 482}, '{3, 723}, '{4, 964}};

   logic clk = 1'b0;
   logic supply_low;
   logic ext_rst_n;
   logic tick;
   logic core_rst;
   logic startup_done;
   logic wd_inhibit;

   int tests = 0;
   int fails = 0;

   brownout_reset_seq dut (
      .clk(clk), .supply_low(supply_low), .ext_rst_n(ext_rst_n), .tick(tick),
      .core_rst(core_rst), .startup_done(startup_done), .wd_inhibit(wd_inhibit)
   );

   initial forever #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic edge1();
      @(posedge clk);
      #1;
   endtask

   // edge 0 is the first edge after the call; tick high when j % d == 0
   task automatic measure(input int d, input int limit, output int at);
      at = -1;
      for (int j = 0; j < limit; j++) begin
         tick = ((j % d) == 0);
         edge1();
         if (!core_rst) begin
            at = j;
            break;
         end
      end
      tick = 1'b1;
   endtask

   task automatic brownout(input int n);
      supply_low = 1'b1;
      for (int k = 0; k < n; k++) edge1();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int at;
      int seen;
      supply_low = 1'b1;
      ext_rst_n  = 1'b1;
      tick       = 1'b0;
      repeat (4) edge1();

      // R1 reset state
      chk("R1 core_rst", core_rst, 1);
      chk("R1 startup_done", startup_done, 0);
      chk("R1 wd_inhibit", wd_inhibit, 1);

      // R2 held while below threshold, ticks running
      seen = 0;
      tick = 1'b1;
      for (int k = 0; k < 600; k++) begin
         edge1();
         if (!core_rst) seen++;
      end
      chk("R2 no release while low", seen, 0);

      // R3 R4 vector table: tick duty patterns
      for (int v = 0; v < NVEC; v++) begin
         brownout(3);
         supply_low = 1'b0;
         measure(VEC[v][0], 2000, at);
         chk($sformatf("R3/R4 release edge div=%0d", VEC[v][0]), at, VEC[v][1]);
      end
      chk("R10 startup_done after release", startup_done, 1);
      chk("R10 wd_inhibit after release", wd_inhibit, 0);

      // R5 brownout after release: immediate, then full countdown
      supply_low = 1'b1;
      #1;
      chk("R5 immediate reassert", core_rst, 1);
      chk("R10 startup_done cleared", startup_done, 0);
      chk("R10 wd_inhibit on reset", wd_inhibit, 1);
      repeat (3) edge1();
      supply_low = 1'b0;
      measure(1, 2000, at);
      chk("R5 full countdown after recovery", at, P + 2);

      // R6 brownout during countdown
      brownout(3);
      supply_low = 1'b0;
      for (int k = 0; k < 100; k++) edge1();
      chk("R6 still counting", core_rst, 1);
      brownout(2);
      supply_low = 1'b0;
      measure(1, 2000, at);
      chk("R6 restart from preset", at, P + 2);

      // R8 short external pulse ignored
      seen = 0;
      ext_rst_n = 1'b0;
      for (int k = 0; k < MINL - 1; k++) begin
         edge1();
         if (core_rst) seen++;
      end
      ext_rst_n = 1'b1;
      for (int k = 0; k < 12; k++) begin
         edge1();
         if (core_rst) seen++;
      end
      chk("R8 short pulse no reset", seen, 0);
      chk("R10 done kept", startup_done, 1);

      // R7 accepted pulse, exact assertion edge
      ext_rst_n = 1'b0;
      for (int j = 0; j < 8; j++) begin
         edge1();
         if (j == MINL + 1) chk("R7 not yet asserted", core_rst, 0);
         if (j == MINL + 2) chk("R7 asserted", core_rst, 1);
      end
      ext_rst_n = 1'b1;
      measure(1, 2000, at);
      chk("R9 release after ext rise", at, P + 3);

      // R9 external reset during countdown
      brownout(3);
      supply_low = 1'b0;
      for (int k = 0; k < 50; k++) edge1();
      ext_rst_n = 1'b0;
      for (int k = 0; k < 8; k++) edge1();
      ext_rst_n = 1'b1;
      measure(1, 2000, at);
      chk("R9 ext during countdown reloads", at, P + 3);

      // R9 pin held low across supply recovery
      ext_rst_n = 1'b0;
      brownout(3);
      supply_low = 1'b0;
      seen = 0;
      for (int k = 0; k < 400; k++) begin
         edge1();
         if (!core_rst) seen++;
      end
      chk("R9 held pin blocks release", seen, 0);
      ext_rst_n = 1'b1;
      measure(1, 2000, at);
      chk("R9 release after pin rises", at, P + 3);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule